// File: doc/BRIEF.md
# Programmable Chip-Select Channel

This block is one chip-select channel for an external bus controller. It is meant to be placed several times: once as the boot channel and once for each general select. The channel receives its window and its options as static configuration words from a neighbouring register file. On every bus cycle it compares the bus address, direction, byte lanes, address space and interrupt level against that window. When all of them agree and the chosen strobe falls, it drives an active-low select. After the programmed number of wait states it returns a termination acknowledge, sized for an 8-bit or a 16-bit port.

A 2-bit pin-function field decides the pin's role. The pin can be a discrete output, an alternate function, an 8-bit select or a 16-bit select. The first two roles silence the channel and raise a mode flag for the pin multiplexer. The boot variant can never leave select mode, so that the first fetch after reset always has a select.

For interrupt-acknowledge cycles, the channel matches the priority level being acknowledged. It can return an autovector request in place of the sized acknowledge.

Top module: `csel_chan`

## Requirements
- R1: Pin field `cfg_pin` encodes 2'b00 discrete output (`mode_dout`=1), 2'b01 alternate function (`mode_alt`=1), 2'b10 8-bit select and 2'b11 16-bit select. In the two non-select roles, `sel_n`, `ack8_n`, `ack16_n` and `avec_n` stay high for any bus activity.
- R2: With parameter `IS_BOOT`=1, the upper pin-field bit is forced to one and writes to it have no effect. `cfg_pin`=2'b00 acts as an 8-bit select and 2'b01 acts as a 16-bit select.
- R3: `cfg_base[15:3]` holds address bits 23:11 and `cfg_base[2:0]` the block-size code: 0=2K, 1=8K, 2=16K, 3=64K, 4=128K, 5=256K, 6=512K, 7=1M bytes. Only the address bits at or above the block size are compared.
- R4: Option bits 12:11 give the allowed direction: 2'b01 reads only (`bus_rnw`=1), 2'b10 writes only, 2'b11 both, 2'b00 neither.
- R5: Option bits 14:13 give the byte lanes: 2'b00 none, 2'b01 lower, 2'b10 upper, 2'b11 both. A cycle matches when it uses at least one enabled lane (`bus_lane` bit 0 lower, bit 1 upper).
- R6: Option bits 5:4 give the space, with `bus_space` encoded 2'b00 CPU, 2'b01 user and 2'b10 supervisor. Option 2'b00 matches CPU space, 2'b01 user, 2'b10 supervisor and 2'b11 either user or supervisor.
- R7: In CPU space, option bits 3:1 must equal `bus_ipl`. The value 0 matches any level.
- R8: Option bit 10 picks the strobe: 0 the address strobe `bus_as_n`, 1 the data strobe `bus_ds_n`. The other strobe has no effect.
- R9: `sel_n` falls after the first clock edge at which the chosen strobe is low and the cycle matches. It rises after the first edge at which that strobe is high.
- R10: For wait code n in option bits 9:6, with n from 0 to 13, the acknowledge falls n+1 cycles after `sel_n` falls.
- R11: Wait code 14 (fast termination) acknowledges together with `sel_n`. Wait code 15 passes `ext_ack_n` through to the acknowledge while the select is active.
- R12: The acknowledge appears on `ack8_n` for pin code 2'b10 and on `ack16_n` for pin code 2'b11, never on both.
- R13: A CPU-space cycle with option bit 0 set acknowledges on `avec_n` instead of the sized acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 16 | Base address bits 23:11 and block-size code |
| cfg_opt | input | 16 | Option word (lanes, direction, strobe, wait code, space, level, autovector) |
| cfg_pin | input | 2 | Pin-function field |
| bus_addr | input | 24 | Bus address |
| bus_rnw | input | 1 | 1 read, 0 write |
| bus_lane | input | 2 | Byte lanes used, bit 0 lower, bit 1 upper |
| bus_space | input | 2 | Address space: 00 CPU, 01 user, 10 supervisor |
| bus_ipl | input | 3 | Interrupt level under acknowledge |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 1 | Data strobe, active low |
| ext_ack_n | input | 1 | External termination, active low |
| sel_n | output | 1 | Chip select, active low |
| ack8_n | output | 1 | 8-bit port acknowledge, active low |
| ack16_n | output | 1 | 16-bit port acknowledge, active low |
| avec_n | output | 1 | Autovector request, active low |
| mode_dout | output | 1 | Pin is a discrete output |
| mode_alt | output | 1 | Pin carries its alternate function |

## Verification
The strobe is driven just after a falling clock edge. The outputs are then sampled 1 ns after each later falling edge, and the sample index counts the rising edges passed.

The select is due at index 0, the first edge after the strobe. A counted acknowledge is due at index n+1. A fast acknowledge is due at index 0. An external acknowledge is due in the same sample in which `ext_ack_n` is driven low.

Release is checked one edge after the strobe rises. Each check compares the first index at which an output fell with the index computed from the requirement, and uses -1 when the output must never fall.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic [1:0] {
    PIN_DOUT = 2'b00,
    PIN_ALT  = 2'b01,
    PIN_CS8  = 2'b10,
    PIN_CS16 = 2'b11
  } pin_fn_e;

  localparam logic [3:0] WAIT_FAST = 4'd14;
  localparam logic [3:0] WAIT_EXT  = 4'd15;

  localparam logic [1:0] SPC_CPU = 2'b00;
  localparam logic [1:0] SPC_USR = 2'b01;
  localparam logic [1:0] SPC_SUP = 2'b10;

  typedef struct packed {
    logic       mode;
    logic [1:0] lanes;
    logic [1:0] dir;
    logic       use_ds;
    logic [3:0] wait_code;
    logic [1:0] space;
    logic [2:0] ipl;
    logic       autovec;
  } opt_t;

endpackage

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LOW_BIT = 11
) (
  input  logic [ADDR_W-LOW_BIT+2:0] base,
  input  opt_t                      opt,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_rnw,
  input  logic [1:0]                bus_lane,
  input  logic [1:0]                bus_space,
  input  logic [2:0]                bus_ipl,
  output logic                      addr_hit
);
  localparam int TAG_W  = ADDR_W - LOW_BIT;
  localparam int BASE_W = TAG_W + 3;

  logic [TAG_W-1:0] care;
  logic [3:0]       shift;
  logic             tag_ok, dir_ok, lane_ok, space_ok, ipl_ok;

  always_comb begin
    unique case (base[2:0])
      3'd0: shift = 4'd0;
      3'd1: shift = 4'd2;
      3'd2: shift = 4'd3;
      3'd3: shift = 4'd5;
      3'd4: shift = 4'd6;
      3'd5: shift = 4'd7;
      3'd6: shift = 4'd8;
      default: shift = 4'd9;
    endcase
    for (int j = 0; j < TAG_W; j++) begin
      care[j] = (j >= int'(shift));
    end
  end

  assign tag_ok  = (((bus_addr[ADDR_W-1:LOW_BIT] ^ base[BASE_W-1:3]) & care) == '0);
  assign dir_ok  = bus_rnw ? opt.dir[0] : opt.dir[1];
  assign lane_ok = |(opt.lanes & bus_lane);

  always_comb begin
    unique case (opt.space)
      2'b00:   space_ok = (bus_space == SPC_CPU);
      2'b01:   space_ok = (bus_space == SPC_USR);
      2'b10:   space_ok = (bus_space == SPC_SUP);
      default: space_ok = (bus_space == SPC_USR) || (bus_space == SPC_SUP);
    endcase
  end

  assign ipl_ok   = (bus_space != SPC_CPU) || (opt.ipl == 3'd0) || (opt.ipl == bus_ipl);
  assign addr_hit = tag_ok && dir_ok && lane_ok && space_ok && ipl_ok;

endmodule

// File: rtl/csel_timer.sv
module csel_timer
  import csel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       strobe_lo,
  input  logic [3:0] wait_code,
  input  logic       is_cpu,
  input  logic       ext_ack_n,
  output logic       sel,
  output logic       ack,
  output logic       cpu_cycle
);
  logic       sel_q, sel_d;
  logic [3:0] cnt_q, cnt_d;
  logic       ext_q, ext_d;
  logic       cpu_q, cpu_d;
  logic       load, cnt_en;

  always_comb begin
    load   = !sel_q && take;
    sel_d  = sel_q ? strobe_lo : take;
    cnt_en = load || (sel_q && (cnt_q != 4'd0));
    if (load) begin
      cnt_d = (wait_code >= WAIT_FAST) ? 4'd0 : wait_code + 4'd1;
    end else begin
      cnt_d = cnt_q - 4'd1;
    end
    ext_d = (wait_code == WAIT_EXT);
    cpu_d = is_cpu;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cnt_q <= 4'd0;
      ext_q <= 1'b0;
      cpu_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (load) begin
        ext_q <= ext_d;
        cpu_q <= cpu_d;
      end
    end
  end

  assign sel       = sel_q;
  assign ack       = sel_q && (ext_q ? !ext_ack_n : (cnt_q == 4'd0));
  assign cpu_cycle = cpu_q;

  // R10: a counted wait never acknowledges on the select edge
  a_r10_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sel_q) && ($past(wait_code) < WAIT_FAST)) |-> !ack);

  // R11: fast termination acknowledges together with the select
  a_r11_fast_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sel_q) && ($past(wait_code) == WAIT_FAST)) |-> ack);

endmodule

// File: rtl/csel_chan.sv
module csel_chan
  import csel_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LOW_BIT = 11,
  parameter bit IS_BOOT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-LOW_BIT+2:0] cfg_base,
  input  logic [15:0]               cfg_opt,
  input  logic [1:0]                cfg_pin,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_rnw,
  input  logic [1:0]                bus_lane,
  input  logic [1:0]                bus_space,
  input  logic [2:0]                bus_ipl,
  input  logic                      bus_as_n,
  input  logic                      bus_ds_n,
  input  logic                      ext_ack_n,
  output logic                      sel_n,
  output logic                      ack8_n,
  output logic                      ack16_n,
  output logic                      avec_n,
  output logic                      mode_dout,
  output logic                      mode_alt
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  opt_t       opt;
  logic [1:0] pin_eff;
  logic       strobe_lo, addr_hit, take, sel, ack, cpu_cycle, use_avec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign opt = opt_t'(cfg_opt);

  generate
    if (IS_BOOT) begin : g_boot_pin
      assign pin_eff = {1'b1, cfg_pin[0]};
    end else begin : g_gen_pin
      assign pin_eff = cfg_pin;
    end
  endgenerate

  assign strobe_lo = opt.use_ds ? !bus_ds_n : !bus_as_n;

  csel_match #(.ADDR_W(ADDR_W), .LOW_BIT(LOW_BIT)) match_i (
    .base      (cfg_base),
    .opt       (opt),
    .bus_addr  (bus_addr),
    .bus_rnw   (bus_rnw),
    .bus_lane  (bus_lane),
    .bus_space (bus_space),
    .bus_ipl   (bus_ipl),
    .addr_hit  (addr_hit)
  );

  assign take = addr_hit && strobe_lo && pin_eff[1];

  csel_timer timer_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .take      (take),
    .strobe_lo (strobe_lo),
    .wait_code (opt.wait_code),
    .is_cpu    (bus_space == SPC_CPU),
    .ext_ack_n (ext_ack_n),
    .sel       (sel),
    .ack       (ack),
    .cpu_cycle (cpu_cycle)
  );

  assign use_avec  = cpu_cycle && opt.autovec;
  assign sel_n     = !sel;
  assign ack8_n    = !(ack && !use_avec && (pin_eff == PIN_CS8));
  assign ack16_n   = !(ack && !use_avec && (pin_eff == PIN_CS16));
  assign avec_n    = !(ack && use_avec);
  assign mode_dout = (pin_eff == PIN_DOUT);
  assign mode_alt  = (pin_eff == PIN_ALT);

  // R9: the select only starts from a matching, strobed cycle
  a_r9_sel_needs_hit: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(sel) |-> $past(addr_hit && strobe_lo));

  // R9: a released strobe ends the select at the next edge
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sel && !strobe_lo) |=> !sel);

  // R12 and R13: at most one termination output at a time
  a_r12_one_ack: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0({!ack8_n, !ack16_n, !avec_n}));

  // R1: non-select roles keep every bus output idle
  a_r1_quiet_pin: assert property (@(posedge clk) disable iff (!rst_core_n)
    !pin_eff[1] |-> (sel_n && ack8_n && ack16_n && avec_n));

endmodule

// File: tb/csel_chan_tb_top.sv
module csel_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_base, cfg_opt;
  logic [1:0]  cfg_pin;
  logic [23:0] bus_addr;
  logic        bus_rnw;
  logic [1:0]  bus_lane, bus_space;
  logic [2:0]  bus_ipl;
  logic        bus_as_n = 1'b1, bus_ds_n = 1'b1, ext_ack_n = 1'b1;
  logic        sel_n, ack8_n, ack16_n, avec_n, mode_dout, mode_alt;
  logic        b_sel_n, b_ack8_n, b_ack16_n, b_avec_n, b_dout, b_alt;

  int n_chk = 0, n_err = 0;
  int r_sel, r_ack, b_sel;
  bit r_a8, r_a16, r_av, b_a8, b_a16, rel_ok;

  always #5 clk = ~clk;

  csel_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_opt(cfg_opt), .cfg_pin(cfg_pin),
    .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_lane(bus_lane), .bus_space(bus_space),
    .bus_ipl(bus_ipl), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .ext_ack_n(ext_ack_n),
    .sel_n(sel_n), .ack8_n(ack8_n), .ack16_n(ack16_n), .avec_n(avec_n),
    .mode_dout(mode_dout), .mode_alt(mode_alt));

  csel_chan #(.IS_BOOT(1'b1)) boot_i (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_opt(cfg_opt), .cfg_pin(cfg_pin),
    .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_lane(bus_lane), .bus_space(bus_space),
    .bus_ipl(bus_ipl), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .ext_ack_n(ext_ack_n),
    .sel_n(b_sel_n), .ack8_n(b_ack8_n), .ack16_n(b_ack16_n), .avec_n(b_avec_n),
    .mode_dout(b_dout), .mode_alt(b_alt));

  function automatic logic [15:0] mk_opt(input logic [1:0] lanes, input logic [1:0] dir,
      input logic ds, input logic [3:0] ws, input logic [1:0] spc, input logic [2:0] ipl,
      input logic av);
    return {1'b0, lanes, dir, ds, ws, spc, ipl, av};
  endfunction

  function automatic logic [15:0] mk_base(input logic [23:0] a, input logic [2:0] bs);
    return {a[23:11], bs};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic defaults();
    cfg_base  = mk_base(24'h123800, 3'd0);
    cfg_opt   = mk_opt(2'b11, 2'b11, 1'b0, 4'd0, 2'b11, 3'd0, 1'b0);
    cfg_pin   = 2'b11;
    bus_addr  = 24'h123800;
    bus_rnw   = 1'b1;
    bus_lane  = 2'b11;
    bus_space = 2'b01;
    bus_ipl   = 3'd0;
  endtask

  // Drive one strobed cycle for 20 clocks; record first fall index of each output.
  task automatic access(input bit use_as, input bit use_ds, input int ext_at);
    r_sel = -1; r_ack = -1; b_sel = -1;
    r_a8 = 0; r_a16 = 0; r_av = 0; b_a8 = 0; b_a16 = 0;
    @(negedge clk); #1;
    bus_as_n = !use_as;
    bus_ds_n = !use_ds;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == ext_at) ext_ack_n = 1'b0;
      #1;
      if (r_sel < 0 && !sel_n) r_sel = i;
      if (b_sel < 0 && !b_sel_n) b_sel = i;
      if (r_ack < 0 && (!ack8_n || !ack16_n || !avec_n)) r_ack = i;
      if (!ack8_n) r_a8 = 1;
      if (!ack16_n) r_a16 = 1;
      if (!avec_n) r_av = 1;
      if (!b_ack8_n) b_a8 = 1;
      if (!b_ack16_n) b_a16 = 1;
    end
    bus_as_n = 1'b1; bus_ds_n = 1'b1; ext_ack_n = 1'b1;
    @(negedge clk); #1;
    rel_ok = sel_n && ack8_n && ack16_n && avec_n && b_sel_n;
  endtask

  task automatic t_reset();
    check("R9 reset sel_n", sel_n, 1);
    check("R12 reset acks", {ack8_n, ack16_n, avec_n}, 3'b111);
    check("R1 16-bit select role flags", {mode_dout, mode_alt}, 2'b00);
  endtask

  task automatic t_basic();
    defaults();
    access(1, 0, -1);
    check("R9 select index", r_sel, 0);
    check("R10 zero-wait ack index", r_ack, 1);
    check("R9 release", rel_ok, 1);
  endtask

  task automatic t_pin();
    defaults(); cfg_pin = 2'b00; #1;
    check("R1 discrete flag", {mode_dout, mode_alt}, 2'b10);
    access(1, 0, -1);
    check("R1 discrete no select", r_sel, -1);
    check("R1 discrete no ack", r_ack, -1);
    check("R2 boot pin 00 selects", b_sel, 0);
    check("R2 boot pin 00 is 8-bit", {b_a8, b_a16}, 2'b10);
    cfg_pin = 2'b01; #1;
    check("R1 alternate flag", {mode_dout, mode_alt}, 2'b01);
    check("R2 boot never alternate", {b_dout, b_alt}, 2'b00);
    access(1, 0, -1);
    check("R1 alternate no select", r_sel, -1);
    check("R2 boot pin 01 is 16-bit", {b_a8, b_a16}, 2'b01);
  endtask

  task automatic t_addr();
    defaults();
    bus_addr = 24'h1237FF; access(1, 0, -1); check("R3 2K below base", r_sel, -1);
    bus_addr = 24'h123FFF; access(1, 0, -1); check("R3 2K top of block", r_sel, 0);
    bus_addr = 24'h124000; access(1, 0, -1); check("R3 2K above block", r_sel, -1);
    cfg_base = mk_base(24'h100000, 3'd7);
    bus_addr = 24'h1FFFFF; access(1, 0, -1); check("R3 1M top", r_sel, 0);
    bus_addr = 24'h200000; access(1, 0, -1); check("R3 1M above", r_sel, -1);
    bus_addr = 24'h0FFFFF; access(1, 0, -1); check("R3 1M below", r_sel, -1);
    cfg_base = mk_base(24'h123800, 3'd3);
    bus_addr = 24'h120000; access(1, 0, -1); check("R3 64K ignores low base bits", r_sel, 0);
    bus_addr = 24'h130000; access(1, 0, -1); check("R3 64K next block", r_sel, -1);
  endtask

  task automatic t_dir();
    defaults();
    cfg_opt = mk_opt(2'b11, 2'b01, 0, 0, 2'b11, 0, 0);
    bus_rnw = 0; access(1, 0, -1); check("R4 read-only rejects write", r_sel, -1);
    bus_rnw = 1; access(1, 0, -1); check("R4 read-only accepts read", r_sel, 0);
    cfg_opt = mk_opt(2'b11, 2'b10, 0, 0, 2'b11, 0, 0);
    access(1, 0, -1); check("R4 write-only rejects read", r_sel, -1);
    bus_rnw = 0; access(1, 0, -1); check("R4 write-only accepts write", r_sel, 0);
    cfg_opt = mk_opt(2'b11, 2'b00, 0, 0, 2'b11, 0, 0);
    access(1, 0, -1); check("R4 direction none", r_sel, -1);
  endtask

  task automatic t_lane();
    defaults();
    cfg_opt = mk_opt(2'b01, 2'b11, 0, 0, 2'b11, 0, 0);
    bus_lane = 2'b10; access(1, 0, -1); check("R5 lower lane rejects upper", r_sel, -1);
    bus_lane = 2'b01; access(1, 0, -1); check("R5 lower lane accepts lower", r_sel, 0);
    cfg_opt = mk_opt(2'b10, 2'b11, 0, 0, 2'b11, 0, 0);
    bus_lane = 2'b11; access(1, 0, -1); check("R5 upper lane on word", r_sel, 0);
    cfg_opt = mk_opt(2'b00, 2'b11, 0, 0, 2'b11, 0, 0);
    access(1, 0, -1); check("R5 lanes disabled", r_sel, -1);
  endtask

  task automatic t_space();
    defaults();
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 0, 2'b01, 0, 0);
    bus_space = 2'b10; access(1, 0, -1); check("R6 user rejects supervisor", r_sel, -1);
    bus_space = 2'b01; access(1, 0, -1); check("R6 user accepts user", r_sel, 0);
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 0, 2'b11, 0, 0);
    bus_space = 2'b10; access(1, 0, -1); check("R6 either accepts supervisor", r_sel, 0);
    bus_space = 2'b00; access(1, 0, -1); check("R6 either rejects CPU", r_sel, -1);
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 0, 2'b00, 0, 0);
    bus_space = 2'b01; access(1, 0, -1); check("R6 CPU rejects user", r_sel, -1);
  endtask

  task automatic t_ipl();
    defaults(); bus_space = 2'b00;
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 0, 2'b00, 3'd3, 0);
    bus_ipl = 3'd3; access(1, 0, -1); check("R7 level match", r_sel, 0);
    bus_ipl = 3'd4; access(1, 0, -1); check("R7 level mismatch", r_sel, -1);
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 0, 2'b00, 3'd0, 0);
    bus_ipl = 3'd5; access(1, 0, -1); check("R7 level any", r_sel, 0);
  endtask

  task automatic t_strobe();
    defaults();
    cfg_opt = mk_opt(2'b11, 2'b11, 1, 0, 2'b11, 0, 0);
    access(1, 0, -1); check("R8 data-strobe option ignores AS", r_sel, -1);
    access(0, 1, -1); check("R8 data-strobe option uses DS", r_sel, 0);
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 0, 2'b11, 0, 0);
    access(0, 1, -1); check("R8 address-strobe option ignores DS", r_sel, -1);
  endtask

  task automatic t_wait();
    defaults();
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 4'd5, 2'b11, 0, 0);
    access(1, 0, -1); check("R10 five waits", r_ack, 6);
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 4'd13, 2'b11, 0, 0);
    access(1, 0, -1); check("R10 thirteen waits", r_ack, 14);
    check("R10 select still at 0", r_sel, 0);
  endtask

  task automatic t_term();
    defaults();
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 4'd14, 2'b11, 0, 0);
    access(1, 0, -1); check("R11 fast termination", r_ack, 0);
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 4'd15, 2'b11, 0, 0);
    access(1, 0, 4); check("R11 external ack passes", r_ack, 4);
    access(1, 0, -1); check("R11 no external ack", r_ack, -1);
    check("R9 release after external", rel_ok, 1);
  endtask

  task automatic t_width();
    defaults(); cfg_pin = 2'b10;
    access(1, 0, -1); check("R12 8-bit ack pin", {r_a8, r_a16, r_av}, 3'b100);
    cfg_pin = 2'b11;
    access(1, 0, -1); check("R12 16-bit ack pin", {r_a8, r_a16, r_av}, 3'b010);
  endtask

  task automatic t_avec();
    defaults(); bus_space = 2'b00;
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 4'd2, 2'b00, 3'd0, 1);
    access(1, 0, -1);
    check("R13 autovector replaces ack", {r_a8, r_a16, r_av}, 3'b001);
    check("R13 autovector timing", r_ack, 3);
    cfg_opt = mk_opt(2'b11, 2'b11, 0, 4'd2, 2'b00, 3'd0, 0);
    access(1, 0, -1);
    check("R13 autovector off", {r_a8, r_a16, r_av}, 3'b010);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_basic();
    t_pin();
    t_addr();
    t_dir();
    t_lane();
    t_space();
    t_ipl();
    t_strobe();
    t_wait();
    t_term();
    t_width();
    t_avec();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule